// File: doc/BRIEF.md
# Dual-Bank Bit Store with Lookup Mode

This block holds 32 bits as two banks of sixteen single-bit cells. A write port and a read port work independently, so one location can be read while a different one is written in the same cycle. One read address picks a cell in each bank at once. Two read enables decide which of the two picked bits reaches the single data output, and when neither is enabled a pass-through input is forwarded to that output instead, so a chain of such blocks can be bypassed one element at a time.

The same storage doubles as a four-input, two-output function table. With the lookup select raised, four function inputs replace the read address and the picked bit of each bank appears on its own output. The table contents are first loaded through the ordinary write port. The read side is purely combinational; only writes and reset use the clock.

Top module: `twin_bank_lut`

## Requirements
- R1: While `rst_n` is low, every cell of both banks is cleared to 0 at the next rising clock edge.
- R2: On a rising edge with `wr_en[0]` high and `wr_en[1]` low, `wr_data` is stored in bank 0 at `wr_addr`, and bank 1 keeps its contents.
- R3: On a rising edge with `wr_en[1]` high and `wr_en[0]` low, `wr_data` is stored in bank 1 at `wr_addr`, and bank 0 keeps its contents. With `wr_en` = 2'b11 both banks store the bit.
- R4: When `rd_en[0]` is high, `data_out` equals the bank 0 cell at the effective read address, whatever `rd_en[1]` is (bank 0 has priority).
- R5: When `rd_en` = 2'b10, `data_out` equals the bank 1 cell at the effective read address.
- R6: When `rd_en` = 2'b00, `data_out` equals `pass_in`.
- R7: Reads are combinational; reading the cell being written in the same cycle returns the old value until the rising edge, and the new value right after it.
- R8: When `lut_mode` is high, the effective read address is `fn_in` and `rd_addr` has no effect; `lut_lo` and `lut_hi` show the bank 0 and bank 1 cells at `fn_in`.
- R9: When `lut_mode` is low, the effective read address is `rd_addr`, and `lut_lo`/`lut_hi` show the two picked cells whatever `rd_en` is.
- R10: With `wr_en` = 2'b00, a rising edge changes no cell, whatever `wr_addr` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low synchronous clear of all cells |
| wr_addr | input | ADDR_W | Write address, common to both banks |
| wr_en | input | 2 | Per-bank write enable, bit b for bank b |
| wr_data | input | 1 | Bit to store |
| rd_addr | input | ADDR_W | Read address in memory mode |
| rd_en | input | 2 | Per-bank read enable, bit 0 has priority |
| pass_in | input | 1 | Bit forwarded when no bank is read-enabled |
| lut_mode | input | 1 | 1 = function inputs address the table |
| fn_in | input | ADDR_W | Function inputs used as address in lookup mode |
| data_out | output | 1 | Selected bank bit or pass-through bit |
| lut_lo | output | 1 | Bank 0 cell at the effective address |
| lut_hi | output | 1 | Bank 1 cell at the effective address |

## Verification
The bench loads distinct patterns into the two banks and sweeps every address against every read-enable combination and both pass-through values, so a design that swapped banks, let bank 1 win when both reads are on, or ignored the bypass would mismatch on many points. Lookup mode is swept with `rd_addr` held at the complement of `fn_in`, which exposes a design that still decodes the memory-mode address. A read of the cell being written is checked on both sides of the edge, catching write-through or a late write, and a cycle with both write enables low but live address and data catches a write path that does not gate on the enables.

// File: rtl/twin_bank_pkg.sv
package twin_bank_pkg;
   localparam int NUM_BANKS = 2;

   typedef enum logic [1:0] {
      SRC_PASS  = 2'd0,
      SRC_BANK0 = 2'd1,
      SRC_BANK1 = 2'd2
   } rd_src_e;

   function automatic rd_src_e pick_source(input logic [NUM_BANKS-1:0] en);
      if (en[0])      return SRC_BANK0;
      else if (en[1]) return SRC_BANK1;
      else            return SRC_PASS;
   endfunction
endpackage

// File: rtl/twin_bank_cells.sv
module twin_bank_cells #(
   parameter int ADDR_W    = 4,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic              wd,
   input  logic [ADDR_W-1:0] ra,
   output logic              rbit
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0] cells;

   generate
      if (CLR_ON_RST) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)  cells <= '0;
            else if (we) cells[wa] <= wd;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) cells[wa] <= wd;
         end
      end
   endgenerate

   assign rbit = cells[ra];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cells[$past(wa)] == $past(wd));                       // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cells));                                      // R10
   generate
      if (CLR_ON_RST) begin : g_clr_chk
         AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |=> cells == '0);                                // R1
      end
   endgenerate
endmodule

// File: rtl/twin_bank_addr_sel.sv
module twin_bank_addr_sel #(
   parameter int ADDR_W = 4
) (
   input  logic              lut_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] fn_in,
   output logic [ADDR_W-1:0] eff_addr
);
   always_comb begin
      if (lut_mode) eff_addr = fn_in;
      else          eff_addr = rd_addr;
   end
endmodule

// File: rtl/twin_bank_out_mux.sv
module twin_bank_out_mux
   import twin_bank_pkg::*;
(
   input  logic [NUM_BANKS-1:0] rd_en,
   input  logic [NUM_BANKS-1:0] bank_bits,
   input  logic                 pass_in,
   output logic                 data_out
);
   rd_src_e src;

   always_comb begin
      src = pick_source(rd_en);
      unique case (src)
         SRC_BANK0: data_out = bank_bits[0];
         SRC_BANK1: data_out = bank_bits[1];
         default:   data_out = pass_in;
      endcase
   end
endmodule

// File: rtl/twin_bank_lut.sv
module twin_bank_lut
   import twin_bank_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_en,
   input  logic              wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_en,
   input  logic              pass_in,
   input  logic              lut_mode,
   input  logic [ADDR_W-1:0] fn_in,
   output logic              data_out,
   output logic              lut_lo,
   output logic              lut_hi
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
         $error("twin_bank_lut: ADDR_W must be within 1..8");
      end
   endgenerate

   logic [ADDR_W-1:0]    eff_addr;
   logic [NUM_BANKS-1:0] bank_bits;

   twin_bank_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
      .lut_mode (lut_mode),
      .rd_addr  (rd_addr),
      .fn_in    (fn_in),
      .eff_addr (eff_addr)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         twin_bank_cells #(.ADDR_W(ADDR_W), .CLR_ON_RST(CLR_ON_RST)) u_cells (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en[b]),
            .wa    (wr_addr),
            .wd    (wr_data),
            .ra    (eff_addr),
            .rbit  (bank_bits[b])
         );
      end
   endgenerate

   twin_bank_out_mux u_mux (
      .rd_en     (rd_en),
      .bank_bits (bank_bits),
      .pass_in   (pass_in),
      .data_out  (data_out)
   );

   assign lut_lo = bank_bits[0];
   assign lut_hi = bank_bits[1];

   AST_BANK0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[0] |-> data_out == lut_lo);                             // R4
   AST_BANK1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en == 2'b10 |-> data_out == lut_hi);                       // R5
   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en == 2'b00 |-> data_out == pass_in);                      // R6
endmodule

// File: tb/tb_twin_bank_lut.sv
module tb_twin_bank_lut;
   localparam int AW = 4;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [1:0]    wr_en = 2'b00;
   logic          wr_data = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [1:0]    rd_en = 2'b00;
   logic          pass_in = 1'b0;
   logic          lut_mode = 1'b0;
   logic [AW-1:0] fn_in = '0;
   logic          data_out, lut_lo, lut_hi;

   logic m0 [N];
   logic m1 [N];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   twin_bank_lut #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_en(rd_en),
      .pass_in(pass_in), .lut_mode(lut_mode), .fn_in(fn_in),
      .data_out(data_out), .lut_lo(lut_lo), .lut_hi(lut_hi)
   );

   always #10 clk = ~clk;

   task automatic chk(input logic act, input logic exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] en, input int a, input logic d);
      @(negedge clk);
      wr_en = en; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 2'b00;
      if (en[0]) m0[a] = d;
      if (en[1]) m1[a] = d;
   endtask

   task automatic sweep_mem(input string tag);
      lut_mode = 1'b0;
      for (int a = 0; a < N; a++) begin
         for (int re = 0; re < 4; re++) begin
            for (int p = 0; p < 2; p++) begin
               logic e;
               rd_addr = AW'(a); rd_en = 2'(re); pass_in = p[0]; fn_in = ~AW'(a);
               #1;
               e = re[0] ? m0[a] : (re[1] ? m1[a] : p[0]);
               if (re == 0) chk(data_out, e, {"R6 ", tag});
               else if (re == 2) chk(data_out, e, {"R5 ", tag});
               else chk(data_out, e, {"R4 ", tag});
               chk(lut_lo, m0[a], {"R9 lo ", tag});
               chk(lut_hi, m1[a], {"R9 hi ", tag});
            end
         end
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < N; a++) begin m0[a] = 1'b0; m1[a] = 1'b0; end
      // fill with ones before reset so a missing clear is visible
      rst_n = 1'b1;
      for (int a = 0; a < N; a++) wr(2'b11, a, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < N; a++) begin m0[a] = 1'b0; m1[a] = 1'b0; end
      // R1: all cells zero after reset
      sweep_mem("R1 reset");

      // R2: bank 0 only, parity pattern
      for (int a = 0; a < N; a++) wr(2'b01, a, ^AW'(a));
      sweep_mem("R2 bank0");
      // R3: bank 1 only, different pattern
      for (int a = 0; a < N; a++) wr(2'b10, a, a[3] ^ ~a[0]);
      sweep_mem("R3 bank1");
      // R3: both banks together on selected addresses
      for (int a = 0; a < N; a += 3) wr(2'b11, a, a[1]);
      sweep_mem("R3 both");

      // R10: enables low, live address/data
      for (int a = 0; a < N; a++) begin
         @(negedge clk);
         wr_en = 2'b00; wr_addr = AW'(a); wr_data = ~m0[a];
      end
      @(negedge clk);
      sweep_mem("R10 idle");

      // R7: read-during-write of the same cell
      @(negedge clk);
      lut_mode = 1'b0; rd_addr = AW'(5); rd_en = 2'b01;
      wr_addr = AW'(5); wr_data = ~m0[5]; wr_en = 2'b01;
      #1 chk(data_out, m0[5], "R7 before edge");
      @(posedge clk); #1;
      chk(data_out, ~m0[5], "R7 after edge");
      m0[5] = ~m0[5];
      @(negedge clk); wr_en = 2'b00;
      rd_en = 2'b10; wr_addr = AW'(9); wr_data = ~m1[9]; wr_en = 2'b10;
      rd_addr = AW'(9);
      #1 chk(data_out, m1[9], "R7 bank1 before edge");
      @(posedge clk); #1;
      chk(data_out, ~m1[9], "R7 bank1 after edge");
      m1[9] = ~m1[9];
      @(negedge clk); wr_en = 2'b00;

      // R8: lookup mode, rd_addr held at complement
      lut_mode = 1'b1;
      for (int a = 0; a < N; a++) begin
         fn_in = AW'(a); rd_addr = ~AW'(a); rd_en = 2'b01; pass_in = 1'b0;
         #1;
         chk(lut_lo, m0[a], "R8 lo");
         chk(lut_hi, m1[a], "R8 hi");
         chk(data_out, m0[a], "R8 data bank0");
         rd_en = 2'b10; #1;
         chk(data_out, m1[a], "R8 data bank1");
      end
      lut_mode = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule